// File: doc/BRIEF.md
# Serial Command and Address Encoder

This block is the controller-side transmitter for a single serial line to a remote device. It takes a 16-bit word and a flag that marks the word as a command or as an address. It sends the flag and the word as a train of pulse-width-coded bit cells. Every cell begins with a rising edge. The far end reads the line twice after each edge: an early sample gives the bit value, and a later sample tells whether more bits follow. The block can also send one isolated low pulse, which asks the remote device to return data.

A client raises `start_i` for one cycle with `word_i` and `is_cmd_i` valid. While `busy_o` is high the block ignores both kinds of request. Timing is counted in clock cycles. The default cell is 12 clocks long, which is 300 ns at the 40 MHz rate the far end decodes at. Its early sample falls near clock 5 after the edge and its late sample near clock 10. The line rests high whenever the block is idle.

Top module: `cmd_addr_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `line_o` is 1 and `busy_o` is 0. A start pulse during reset is ignored.
- R2: A `start_i` pulse taken while `busy_o` is 0 makes `busy_o` 1 after that clock edge. On the next edge `line_o` goes low for exactly one clock (the lead). The first cell's rising edge follows.
- R3: A word frame is 18 cells of 12 clocks each, sent in this order: the type bit, the 16 word bits starting with bit 15, then a terminator. A far-end reader that samples 5 clocks after each rising edge recovers {type, word, 1}.
- R4: In a non-terminating cell, counted from its rising edge at clock 0, the line is high for clocks 0–2. It carries the bit value for clocks 3–7 and is low for clocks 8–11, so the sample at clock 10 reads low, meaning more bits follow.
- R5: The terminating cell is high for all 12 clocks, and the line then stays high. A clock-10 sample therefore reads high only in the 18th cell.
- R6: The type bit is 1 when `is_cmd_i` was 1 at the start pulse (a command) and 0 otherwise (an address).
- R7: `busy_o` stays 1 from the clock after the start pulse until the terminator's last clock has been on the line. It is 0 on the next clock.
- R8: `start_i` and `rd_req_i` have no effect while `busy_o` is 1. This holds in the final busy cycle too. The frame in progress goes on unchanged, and no new frame or pulse follows it.
- R9: A `rd_req_i` pulse taken while idle drives the line low for 5 clocks, then high. `busy_o` stays 1 for 16 further clocks of high level, then falls.
- R10: When `start_i` and `rd_req_i` are taken in the same cycle, the word frame is sent and the read request is dropped.
- R11: When no frame or pulse is in progress, the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send a word frame |
| is_cmd_i | input | 1 | 1: word is a command, 0: word is an address |
| word_i | input | 16 | Word to send, bit 15 first |
| rd_req_i | input | 1 | One-cycle request to send the data-read low pulse |
| busy_o | output | 1 | High while a frame or pulse is in progress |
| line_o | output | 1 | Serial line level, registered |

## Verification
The bench builds the block with its default parameters: a 16-bit word, 12-clock cells with the bit level at clocks 3–7, a one-clock lead, a 5-clock request pulse and a 16-clock trailing high. With these values a full frame takes 217 line clocks. Many randomly chosen words and types therefore fit in one run, and each frame is checked clock by clock and also decoded by a far-end style sampler at clocks 5 and 10 after each edge. The defaults also bring within reach the ignored requests at the first clock of a frame, in its middle and in the final busy cycle, as well as the start-and-read collision and back-to-back frames.

// File: rtl/cmd_addr_encoder_pkg.sv
package cmd_addr_encoder_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CELL,
    ST_REQLO,
    ST_REQHI
  } enc_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/enc_ctrl.sv
module enc_ctrl
  import cmd_addr_encoder_pkg::*;
#(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned CELL_CLKS    = 12,
  parameter int unsigned LEAD_CLKS    = 1,
  parameter int unsigned REQ_LOW_CLKS = 5,
  parameter int unsigned REQ_GAP_CLKS = 16,
  parameter int unsigned POS_W        = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rd_req_i,
  output enc_state_e       state_o,
  output logic [POS_W-1:0] pos_o,
  output logic             term_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             busy_o
);

  localparam int unsigned N_CELLS = WORD_W + 2;
  localparam int unsigned CELL_W  = $clog2(N_CELLS);

  enc_state_e        state_q, state_n;
  logic [POS_W-1:0]  pos_q, pos_n, span_last;
  logic [CELL_W-1:0] cell_q, cell_n;
  logic              busy_q, acc_word, acc_req, last_pos, term;

  assign acc_word = start_i & ~busy_q;
  assign acc_req  = rd_req_i & ~busy_q & ~start_i;
  assign term     = (cell_q == CELL_W'(N_CELLS - 1));

  always_comb begin
    case (state_q)
      ST_LEAD:  span_last = POS_W'(LEAD_CLKS - 1);
      ST_CELL:  span_last = POS_W'(CELL_CLKS - 1);
      ST_REQLO: span_last = POS_W'(REQ_LOW_CLKS - 1);
      ST_REQHI: span_last = POS_W'(REQ_GAP_CLKS - 1);
      default:  span_last = '0;
    endcase
  end

  assign last_pos = (pos_q == span_last);

  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    cell_n  = cell_q;
    if (state_q == ST_IDLE) begin
      if (acc_word) begin
        state_n = ST_LEAD;
        pos_n   = '0;
      end else if (acc_req) begin
        state_n = ST_REQLO;
        pos_n   = '0;
      end
    end else if (!last_pos) begin
      pos_n = pos_q + 1'b1;
    end else begin
      pos_n = '0;
      case (state_q)
        ST_LEAD: begin
          state_n = ST_CELL;
          cell_n  = '0;
        end
        ST_CELL: begin
          if (term) state_n = ST_IDLE;
          else      cell_n  = cell_q + 1'b1;
        end
        ST_REQLO: state_n = ST_REQHI;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      cell_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pos_q   <= pos_n;
      cell_q  <= cell_n;
      busy_q  <= (state_n != ST_IDLE) | (state_q != ST_IDLE);
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign term_o  = term;
  assign load_o  = (state_q == ST_IDLE) & acc_word;
  assign adv_o   = (state_q == ST_CELL) & last_pos & ~term;
  assign busy_o  = busy_q;

  // R8: the last busy cycle is idle, and nothing may start from it
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && busy_q) |=> (state_q == ST_IDLE));

  // R7: any active state keeps busy high on the next clock
  p_busy_span_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> busy_q);

  // R5: the terminator's last clock ends the frame
  p_term_end_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CELL && term && last_pos) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/enc_shift.sv
module enc_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              is_cmd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);

  logic [WORD_W:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst)         sreg_q <= '0;
    else if (load_i) sreg_q <= {is_cmd_i, word_i};
    else if (adv_i)  sreg_q <= {sreg_q[WORD_W-1:0], 1'b0};
  end

  assign bit_o = sreg_q[WORD_W];

  // R3: a load and a shift never meet in one cycle
  p_load_vs_shift_r3: assert property (@(posedge clk) disable iff (rst)
    adv_i |-> !load_i);

endmodule

// File: rtl/enc_shaper.sv
module enc_shaper
  import cmd_addr_encoder_pkg::*;
#(
  parameter int unsigned DATA_AT = 3,
  parameter int unsigned STAT_AT = 8,
  parameter int unsigned POS_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  enc_state_e       state_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             term_i,
  input  logic             bit_i,
  output logic             line_o
);

  logic lvl, line_q;

  always_comb begin
    case (state_i)
      ST_LEAD, ST_REQLO: lvl = 1'b0;
      ST_CELL: begin
        if (term_i)                        lvl = 1'b1;
        else if (pos_i < POS_W'(DATA_AT))  lvl = 1'b1;
        else if (pos_i < POS_W'(STAT_AT))  lvl = bit_i;
        else                               lvl = 1'b0;
      end
      default: lvl = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= lvl;
  end

  assign line_o = line_q;

  // R2: the lead clock puts a low level on the line
  p_lead_low_r2: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_LEAD) |=> !line_o);

  // R9: the request pulse is low
  p_req_low_r9: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_REQLO) |=> !line_o);

  // R5: the terminator cell is high throughout
  p_term_high_r5: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_CELL && term_i) |=> line_o);

  // R11: idle keeps the line high
  p_idle_high_r11: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_IDLE) |=> line_o);

  // R4: the status segment of a cell that has more to follow is low
  p_status_low_r4: assert property (@(posedge clk) disable iff (rst)
    (state_i == ST_CELL && !term_i && pos_i >= POS_W'(STAT_AT)) |=> !line_o);

endmodule

// File: rtl/cmd_addr_encoder.sv
module cmd_addr_encoder
  import cmd_addr_encoder_pkg::*;
#(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned CELL_CLKS    = 12,
  parameter int unsigned DATA_AT      = 3,
  parameter int unsigned STAT_AT      = 8,
  parameter int unsigned LEAD_CLKS    = 1,
  parameter int unsigned REQ_LOW_CLKS = 5,
  parameter int unsigned REQ_GAP_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              is_cmd_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_req_i,
  output logic              busy_o,
  output logic              line_o
);

  localparam int unsigned POS_MAX = max_of(max_of(CELL_CLKS, LEAD_CLKS),
                                           max_of(REQ_LOW_CLKS, REQ_GAP_CLKS));
  localparam int unsigned POS_W   = $clog2(POS_MAX + 1);

  enc_state_e       state;
  logic [POS_W-1:0] pos;
  logic             term, load, adv, cur_bit;

  enc_ctrl #(
    .WORD_W(WORD_W), .CELL_CLKS(CELL_CLKS), .LEAD_CLKS(LEAD_CLKS),
    .REQ_LOW_CLKS(REQ_LOW_CLKS), .REQ_GAP_CLKS(REQ_GAP_CLKS), .POS_W(POS_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_req_i(rd_req_i),
    .state_o(state), .pos_o(pos), .term_o(term), .load_o(load),
    .adv_o(adv), .busy_o(busy_o)
  );

  enc_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .adv_i(adv),
    .is_cmd_i(is_cmd_i), .word_i(word_i), .bit_o(cur_bit)
  );

  enc_shaper #(.DATA_AT(DATA_AT), .STAT_AT(STAT_AT), .POS_W(POS_W)) u_shaper (
    .clk(clk), .rst(rst), .state_i(state), .pos_i(pos), .term_i(term),
    .bit_i(cur_bit), .line_o(line_o)
  );

endmodule

// File: tb/test_cmd_addr_encoder.sv
module test_cmd_addr_encoder;

  localparam int FRAME = 1 + 18 * 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        is_cmd_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        rd_req_i = 1'b0;
  logic        busy_o, line_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  cmd_addr_encoder i_cmd_addr_encoder (
    .clk(clk), .rst(rst), .start_i(start_i), .is_cmd_i(is_cmd_i),
    .word_i(word_i), .rd_req_i(rd_req_i), .busy_o(busy_o), .line_o(line_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // line level expected j clocks after the first line clock of a frame
  function automatic logic exp_line(input int j, input logic cmd, input logic [15:0] w);
    int  c, p;
    logic b;
    if (j == 0) return 1'b0;
    c = (j - 1) / 12;
    p = (j - 1) % 12;
    if (c == 17) return 1'b1;
    b = (c == 0) ? cmd : w[16 - c];
    if (p < 3) return 1'b1;
    if (p < 8) return b;
    return 1'b0;
  endfunction

  function automatic string tag_of(input int j);
    int c;
    if (j == 0) return "R2";
    c = (j - 1) / 12;
    if (c == 0)  return "R6";
    if (c == 17) return "R5";
    return "R4";
  endfunction

  task automatic run_frame(input logic cmd, input logic [15:0] w,
                           input logic with_req, input logic noise);
    logic        prev, v;
    int          edge_j, ncell, done_at;
    logic [17:0] dec;
    @(negedge clk);
    start_i = 1'b1; is_cmd_i = cmd; word_i = w; rd_req_i = with_req;
    @(negedge clk);
    start_i = 1'b0; rd_req_i = 1'b0; is_cmd_i = ~cmd; word_i = ~w;
    check("R2 busy after start", busy_o, 1'b1);
    check("R11 line before lead", line_o, 1'b1);
    prev = 1'b1; edge_j = -100; ncell = 0; done_at = -1; dec = '0;
    for (int j = 0; j < FRAME; j++) begin
      if (noise && (j == 40 || j == 0)) begin start_i = 1'b1; rd_req_i = 1'b1; end
      if (noise && (j == 41 || j == 1)) begin start_i = 1'b0; rd_req_i = 1'b0; end
      @(negedge clk);
      v = line_o;
      check(tag_of(j), v, exp_line(j, cmd, w));
      check("R7 busy during frame", busy_o, 1'b1);
      if (!prev && v) edge_j = j;
      if (j == edge_j + 5) begin dec = {dec[16:0], v}; ncell++; end
      if (j == edge_j + 10 && v && done_at < 0) done_at = ncell;
      prev = v;
    end
    check("R3 decoded type/word/terminator", dec, {cmd, w, 1'b1});
    check("R3 cell count", ncell, 18);
    check("R5 end seen at cell 18", done_at, 18);
    if (noise) start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy falls after terminator", busy_o, 1'b0);
    check("R5 line high after frame", line_o, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 no frame from ignored start", line_o, 1'b1);
      check("R8 still idle", busy_o, 1'b0);
    end
  endtask

  task automatic run_req(input logic noise);
    @(negedge clk);
    rd_req_i = 1'b1;
    @(negedge clk);
    rd_req_i = 1'b0;
    check("R9 busy after request", busy_o, 1'b1);
    for (int j = 0; j < 21; j++) begin
      if (noise && j == 3) begin start_i = 1'b1; rd_req_i = 1'b1; end
      if (noise && j == 4) begin start_i = 1'b0; rd_req_i = 1'b0; end
      @(negedge clk);
      check("R9 request line", line_o, (j < 5) ? 1'b0 : 1'b1);
      check("R9 busy in request", busy_o, 1'b1);
    end
    @(negedge clk);
    check("R9 busy falls after gap", busy_o, 1'b0);
    check("R11 line idle", line_o, 1'b1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R8 no pulse from ignored request", line_o, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    start_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 line in reset", line_o, 1'b1);
    check("R1 busy in reset", busy_o, 1'b0);
    start_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 line after reset", line_o, 1'b1);
    check("R1 busy after reset", busy_o, 1'b0);

    run_frame(1'b1, 16'hFFFF, 1'b0, 1'b0);   // R6 command, all ones
    run_frame(1'b0, 16'h0000, 1'b0, 1'b0);   // R6 address, all zeros
    run_frame(1'b1, 16'h8001, 1'b0, 1'b1);   // R8 ignored requests
    run_frame(1'b0, 16'h5A5A, 1'b1, 1'b0);   // R10 collision, frame wins
    run_req(1'b0);                           // R9
    run_req(1'b1);                           // R8 during request
    for (int n = 0; n < 24; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) run_req(r[4]);
      else run_frame(r[5], r[31:16], r[6], r[7]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule